// File: doc/BRIEF.md
# Software-Refilled Fully Associative Translation Cache

This block caches recent address translations for a processor core. Each of its slots pairs a virtual page number (the tag) with a page table entry (the value), and any slot may hold any translation. Every memory reference presents its virtual page number. All slots compare against it at once, and the block answers in the same cycle with either a hit and the cached entry, or a miss.

The block does not walk page tables. A miss raises an exception output, and the trap handler computes the translation and installs it through a fill port. A fill whose tag is already cached overwrites that slot. Any other fill takes the slot chosen by a rotating victim pointer. A single-cycle flush empties the cache on a context switch. When a cached entry is found but its present bit is clear, the block reports a page fault instead of a miss, so the handler can tell a missing page apart from a missing translation.

Top module: `sw_tlb`

## Requirements
- R1: After reset, no slot is valid and every lookup misses.
- R2: A lookup (`lk_req`=1) asserts `lk_hit` in the same cycle when a valid slot's tag equals `lk_vpn`.
- R3: On a hit, `lk_pte` carries the value stored in the matching slot. When `lk_hit` is 0, `lk_pte` is zero.
- R4: A lookup that finds no valid matching slot asserts `miss_exc` in the same cycle and leaves `lk_hit` low. When `lk_req` is 0, `lk_hit`, `miss_exc` and `page_fault` are all low.
- R5: A fill whose tag equals the tag of a valid slot overwrites that slot's value. It does not move the victim pointer, and it never leaves two slots with the same tag.
- R6: A fill with a new tag writes the slot named by the victim pointer. The pointer starts at slot 0 after reset and advances by one, modulo 8, after each such fill.
- R7: `flush_all` clears every valid bit at the next edge. A lookup in the flush cycle misses, and a fill in the flush cycle is discarded.
- R8: A hit on a slot whose value has bit 0 (present) equal to 0 asserts `page_fault` together with `lk_hit`, with `miss_exc` low.
- R9: A lookup in the same cycle as a fill sees the contents from before that fill. The fill becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 22 | Virtual page number to translate |
| lk_hit | output | 1 | Translation found |
| lk_pte | output | 32 | Cached page table entry (zero on miss) |
| miss_exc | output | 1 | Translation miss exception |
| page_fault | output | 1 | Hit on an entry whose present bit is clear |
| fill_en | input | 1 | Software fill strobe |
| fill_vpn | input | 22 | Tag to install |
| fill_pte | input | 32 | Entry to install |
| flush_all | input | 1 | Invalidate every slot |

## Verification
The directed patterns follow a fixed order:
- A lookup straight after reset.
- Eight fills of distinct tags, each paired with a same-cycle lookup of the tag being filled. This separates reading the old contents from a write-through path.
- Lookups of every cached tag, including one whose present bit is clear.
- A fill of an already cached tag, followed by two new tags. These show whether the overwrite wrongly moved the victim pointer, because the expected victims are slots 0 and then 1.
- A flush combined with a lookup and a fill, which tests the flush priority.

A long pseudo-random mix then draws tags from a small pool, so hits, overwrites, evictions and flushes interleave. A behavioural model is compared against the design on every cycle of this mix.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_VPN_W   = 22;
  localparam int unsigned DEF_PTE_W   = 32;

  // Rotating victim arithmetic: one step forward, wrapping at the slot count.
  function automatic int unsigned next_slot(input int unsigned cur, input int unsigned count);
    return (cur + 1 >= count) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot #(
  parameter int unsigned VPN_W = 22,
  parameter int unsigned PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PTE_W-1:0] wr_pte,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             valid,
  output logic             look_match,
  output logic             fill_match,
  output logic [PTE_W-1:0] pte
);
  logic             valid_q;
  logic [VPN_W-1:0] tag_q;
  logic [PTE_W-1:0] pte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      pte_q   <= '0;
    end else if (clr) begin
      valid_q <= 1'b0;
    end else if (wr) begin
      valid_q <= 1'b1;
      tag_q   <= wr_vpn;
      pte_q   <= wr_pte;
    end
  end

  assign valid      = valid_q;
  assign look_match = valid_q && (tag_q == look_vpn);
  assign fill_match = valid_q && (tag_q == wr_vpn);
  assign pte        = pte_q;

  assert_slot_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !valid_q);
  assert_slot_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> (valid_q && tag_q == $past(wr_vpn)));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  import sw_tlb_pkg::*;

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (advance) ptr_q <= IDX_W'(next_slot({{(32-IDX_W){1'b0}}, ptr_q}, ENTRIES));
  end

  assign ptr = ptr_q;

  assert_ptr_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr_q));
  assert_ptr_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> ptr_q != $past(ptr_q));
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb #(
  parameter int unsigned ENTRIES     = sw_tlb_pkg::DEF_ENTRIES,
  parameter int unsigned VPN_W       = sw_tlb_pkg::DEF_VPN_W,
  parameter int unsigned PTE_W       = sw_tlb_pkg::DEF_PTE_W,
  parameter int unsigned PRESENT_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PTE_W-1:0] lk_pte,
  output logic             miss_exc,
  output logic             page_fault,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PTE_W-1:0] fill_pte,
  input  logic             flush_all
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Named internal events for the assertions.
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] look_match;
  logic [ENTRIES-1:0] fill_match;
  logic [PTE_W-1:0]   slot_pte [ENTRIES];
  logic [PTE_W-1:0]   sel_pte;
  logic [IDX_W-1:0]   victim;
  logic               fill_go;
  logic               fill_hit;
  logic               alloc_new;
  logic               any_match;

  assign fill_go   = fill_en && !flush_all;
  assign fill_hit  = |fill_match;
  assign alloc_new = fill_go && !fill_hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic wr_i;
    assign wr_i = fill_go && (fill_hit ? fill_match[i] : (victim == IDX_W'(i)));
    tlb_slot #(.VPN_W(VPN_W), .PTE_W(PTE_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (flush_all),
      .wr         (wr_i),
      .wr_vpn     (fill_vpn),
      .wr_pte     (fill_pte),
      .look_vpn   (lk_vpn),
      .valid      (valid_vec[i]),
      .look_match (look_match[i]),
      .fill_match (fill_match[i]),
      .pte        (slot_pte[i])
    );
  end

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (alloc_new),
    .ptr     (victim)
  );

  always_comb begin
    sel_pte = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (look_match[i]) sel_pte = sel_pte | slot_pte[i];
  end

  assign any_match  = |look_match;
  assign lk_hit     = lk_req && !flush_all && any_match;
  assign lk_pte     = lk_hit ? sel_pte : '0;
  assign miss_exc   = lk_req && !lk_hit;
  assign page_fault = lk_hit && !sel_pte[PRESENT_BIT];

  assert_unique_tags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));
  assert_hit_miss_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && miss_exc));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> (!lk_hit && !miss_exc && !page_fault));
  assert_fault_on_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    page_fault |-> (lk_hit && !miss_exc));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));
  assert_flush_lookup_misses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && lk_req) |-> miss_exc);
endmodule

// File: tb/sw_tlb_bench.sv
`timescale 1ns/1ps
module sw_tlb_bench;
  localparam int N  = 8;
  localparam int VW = 22;
  localparam int PW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          lk_req;
  logic [VW-1:0] lk_vpn;
  logic          lk_hit;
  logic [PW-1:0] lk_pte;
  logic          miss_exc;
  logic          page_fault;
  logic          fill_en;
  logic [VW-1:0] fill_vpn;
  logic [PW-1:0] fill_pte;
  logic          flush_all;

  sw_tlb u_sw_tlb (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
    .lk_pte(lk_pte), .miss_exc(miss_exc), .page_fault(page_fault), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pte(fill_pte), .flush_all(flush_all)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural reference: plain arrays and an integer victim index.
  bit            m_v [N];
  logic [VW-1:0] m_t [N];
  logic [PW-1:0] m_p [N];
  int            m_ptr = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    bit            e_hit = 0;
    logic [PW-1:0] e_pte = '0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_t[i] == lk_vpn) begin e_hit = 1; e_pte = m_p[i]; end
    if (!lk_req || flush_all) e_hit = 0;
    if (!e_hit) e_pte = '0;
    chk(req,  "lk_hit",     64'(lk_hit),     64'(e_hit));
    chk("R3", "lk_pte",     64'(lk_pte),     64'(e_pte));
    chk("R4", "miss_exc",   64'(miss_exc),   64'(lk_req && !e_hit));
    chk("R8", "page_fault", 64'(page_fault), 64'(e_hit && !e_pte[0]));
  endtask

  task automatic model_edge();
    if (flush_all) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (fill_en) begin
      int found = -1;
      for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == fill_vpn) found = i;
      if (found >= 0) m_p[found] = fill_pte;
      else begin
        m_v[m_ptr] = 1; m_t[m_ptr] = fill_vpn; m_p[m_ptr] = fill_pte;
        m_ptr = (m_ptr + 1) % N;
      end
    end
  endtask

  task automatic step(string req, bit lr, logic [VW-1:0] lv, bit fe,
                      logic [VW-1:0] fv, logic [PW-1:0] fp, bit fl);
    lk_req = lr; lk_vpn = lv; fill_en = fe; fill_vpn = fv; fill_pte = fp; flush_all = fl;
    #1 compare(req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lfsr = 32'h1ace;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_t[i] = '0; m_p[i] = '0; end
    rst_n = 0; lk_req = 0; lk_vpn = '0; fill_en = 0; fill_vpn = '0; fill_pte = '0; flush_all = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    step("R1", 1, 22'h0, 0, '0, '0, 0);
    step("R1", 1, 22'h100, 0, '0, '0, 0);
    // Fill eight tags; each cycle also looks up the tag being written (R9).
    for (int i = 0; i < N; i++)
      step("R9", 1, VW'(22'h100 + i), 1, VW'(22'h100 + i),
           {8'hA0 + 8'(i), 23'h0, (i != 3)}, 0);
    for (int i = 0; i < N; i++) step("R2", 1, VW'(22'h100 + i), 0, '0, '0, 0);
    step("R8", 1, 22'h103, 0, '0, '0, 0);
    step("R4", 1, 22'h3ff, 0, '0, '0, 0);
    // Overwrite an existing tag: no duplicate, pointer unchanged (R5).
    step("R5", 0, '0, 1, 22'h105, 32'h5555_0001, 0);
    step("R5", 1, 22'h105, 0, '0, '0, 0);
    // New tags evict slot 0 then slot 1 (R6).
    step("R6", 0, '0, 1, 22'h200, 32'h0200_0001, 0);
    step("R6", 1, 22'h100, 0, '0, '0, 0);
    step("R6", 1, 22'h200, 0, '0, '0, 0);
    step("R6", 1, 22'h101, 0, '0, '0, 0);
    step("R6", 0, '0, 1, 22'h201, 32'h0201_0001, 0);
    step("R6", 1, 22'h101, 0, '0, '0, 0);
    step("R6", 1, 22'h102, 0, '0, '0, 0);
    // Idle lookup of a cached tag stays quiet (R4).
    step("R4", 0, 22'h102, 0, '0, '0, 0);
    // Flush with a same-cycle lookup and fill (R7).
    step("R7", 1, 22'h102, 1, 22'h300, 32'h0300_0001, 1);
    step("R7", 1, 22'h300, 0, '0, '0, 0);
    step("R7", 1, 22'h102, 0, '0, '0, 0);
    step("R6", 0, '0, 1, 22'h301, 32'h0301_0001, 0);
    step("R6", 1, 22'h301, 0, '0, '0, 0);

    for (int c = 0; c < 800; c++) begin
      int r;
      lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 32'h1 : 32'h0);
      r = lfsr;
      step("R2", r[0], VW'(22'h40 + (r[7:4] % 12)), r[1] & r[2],
           VW'(22'h40 + (r[11:8] % 12)), {r[27:12], 15'h0, r[3]}, (r[15:9] == 7'h0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule